// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus cycles of a 16-bit processor whose low address bits and data share one set of lines. An internal agent offers one request at a time. Each request carries:

- a 3-bit cycle kind;
- a 20-bit address;
- a word/byte flag;
- write data;
- a flag that tells the block not to wait for READY.

The block accepts the request when it is idle. It then steps through four bus phases. In the first phase it places the address and the cycle's status code on the pins and pulses the latch strobe. In the middle phases it drives the read or write strobe and the transceiver enable. In the last phase it releases the strobes and reports completion.

An external device slows a cycle by holding READY low during the third phase. Every clock with READY low adds one wait clock. When the no-wait flag is set, READY is ignored and every cycle takes the same number of clocks. Read data is taken from the shared lines on the clock edge that ends the last wait clock. It is returned with a one-clock done pulse.

All pin outputs come straight from flops, so external logic sees outputs free of glitches.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst` is high, `req_ack` stays low. From the first clock edge with `rst` high: `rd_n`, `wr_n`, `den_n` and `bhe_n` are 1, `ale` and `ad_oe` are 0, `sts` is 3'b111, `addr_hi` is 0 and `done` is 0.
- R2: `req_kind` has the following codes: 0 interrupt acknowledge, 1 I/O read, 2 I/O write, 3 halt, 4 instruction fetch, 5 memory read, 6 memory write, 7 refresh. In the first phase, `sts` equals the kind code, except for refresh (7), which shows 3'b101. In every other clock, `sts` is 3'b111 (passive).
- R3: In the first phase, `addr_hi` carries address bits 19..16, and `ad_out` carries bits 15..0 with `ad_oe` high. In all other clocks, `addr_hi` is 0.
- R4: An accepted cycle occupies first phase, second phase, one or more third-phase clocks, then fourth phase, one clock each, and then returns to idle. `ale` is high only during the first-phase clock.
- R5: `bhe_n` and `ad_out[0]` are valid in the first phase, and `bhe_n` holds its value until the fourth phase ends. The lane codes are (A0, BHE): word = (0, 0), even byte = (0, 1), odd byte = (1, 0), refresh = (1, 1). A0 is forced to 1 for refresh. Word requests use even addresses.
- R6: When the no-wait flag is clear, every clock edge in the third phase with `ready_in` low keeps the cycle in the third phase. The first edge with `ready_in` high moves it to the fourth phase.
- R7: When `req_no_wait` is high at acceptance, the third phase lasts exactly one clock whatever `ready_in` does.
- R8: For read kinds (0, 1, 4, 5), `rd_n` and `den_n` are low from the second phase through the last third-phase clock, and `ad_oe` is low. `rd_n` and `wr_n` are never low together, and `den_n` is high whenever `ale` is high.
- R9: For read kinds, `rd_data` takes the value of `ad_in` sampled on the edge that ends the last third-phase clock, and holds it afterwards. `done` is high for exactly the fourth-phase clock of every cycle.
- R10: For write kinds (2, 6), `wr_n` is low from the second phase through the last third-phase clock. `ad_out` equals the write data with `ad_oe` high, and `den_n` is low, from the second phase through the fourth phase.
- R11: For halt (3) and refresh (7), `rd_n`, `wr_n` and `den_n` stay high for the whole cycle, and `ad_oe` is low after the first phase.
- R12: `req_ack` is high only when the block is idle, `req_valid` is high and `rst` is low. The clock after a request is accepted is the first phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 20 | Physical address |
| req_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| req_wdata | input | 16 | Write data |
| req_no_wait | input | 1 | Ignore READY for this cycle |
| req_ack | output | 1 | Request taken this clock |
| ready_in | input | 1 | Active-high READY from the bus |
| ad_in | input | 16 | Shared lines as seen from the bus |
| ad_out | output | 16 | Address or write data driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| addr_hi | output | 4 | Upper address bits, zero outside the first phase |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| den_n | output | 1 | Active-low data transceiver enable |
| bhe_n | output | 1 | Active-low upper byte enable |
| sts | output | 3 | Bus status code |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |

## Verification
The bench runs all eight cycle kinds, which separates strobe-driving reads and writes from the strobeless halt and refresh cycles, and checks each status code in its own cycle. Word, even-byte, odd-byte and refresh accesses each give a different pair of BHE and A0 values. Wait counts of 0, 1, 2, 3 and 5 show how READY stretches the third phase. A run that holds READY low with the no-wait flag set shows that READY is then ignored. The bus value changes between third-phase clocks, so a capture one clock early or late returns the wrong word.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_STRB,
    PH_WAIT,
    PH_END
  } phase_e;

  localparam logic [2:0] CK_INTA    = 3'd0;
  localparam logic [2:0] CK_IO_RD   = 3'd1;
  localparam logic [2:0] CK_IO_WR   = 3'd2;
  localparam logic [2:0] CK_HALT    = 3'd3;
  localparam logic [2:0] CK_FETCH   = 3'd4;
  localparam logic [2:0] CK_MEM_RD  = 3'd5;
  localparam logic [2:0] CK_MEM_WR  = 3'd6;
  localparam logic [2:0] CK_REFRESH = 3'd7;

  localparam logic [2:0] STS_PASSIVE = 3'b111;

  function automatic logic [2:0] kind_status(input logic [2:0] k);
    return (k == CK_REFRESH) ? CK_MEM_RD : k;
  endfunction

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == CK_INTA) || (k == CK_IO_RD) || (k == CK_FETCH) || (k == CK_MEM_RD);
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == CK_IO_WR) || (k == CK_MEM_WR);
  endfunction

endpackage

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_no_wait,
  input  logic              ready_in,
  output logic              req_ack,
  output phase_e            phase,
  output phase_e            nxt_phase,
  output logic [2:0]        sel_kind,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_word,
  output logic [DATA_W-1:0] sel_wdata
);

  logic [2:0]        lat_kind;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_word;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_no_wait;

  assign req_ack = req_valid && !rst && (phase == PH_IDLE);

  always_comb begin
    nxt_phase = phase;
    case (phase)
      PH_IDLE: if (req_ack) nxt_phase = PH_ADDR;
      PH_ADDR: nxt_phase = PH_STRB;
      PH_STRB: nxt_phase = PH_WAIT;
      PH_WAIT: if (ready_in || lat_no_wait) nxt_phase = PH_END;
      PH_END:  nxt_phase = PH_IDLE;
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      lat_kind    <= '0;
      lat_addr    <= '0;
      lat_word    <= 1'b0;
      lat_wdata   <= '0;
      lat_no_wait <= 1'b0;
    end else begin
      phase <= nxt_phase;
      if (req_ack) begin
        lat_kind    <= req_kind;
        lat_addr    <= req_addr;
        lat_word    <= req_word;
        lat_wdata   <= req_wdata;
        lat_no_wait <= req_no_wait;
      end
    end
  end

  assign sel_kind  = req_ack ? req_kind  : lat_kind;
  assign sel_addr  = req_ack ? req_addr  : lat_addr;
  assign sel_word  = req_ack ? req_word  : lat_word;
  assign sel_wdata = req_ack ? req_wdata : lat_wdata;

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && !ready_in && !lat_no_wait) |=> (phase == PH_WAIT));

  p_ready_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && ready_in) |=> (phase == PH_END));

  p_ignore_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && lat_no_wait) |=> (phase == PH_END));

  p_ack_start_r12: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> (phase == PH_ADDR));

  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR) |=> (phase == PH_STRB));

endmodule

// File: rtl/bcc_pin_driver.sv
module bcc_pin_driver
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  phase_e                   phase,
  input  phase_e                   nxt_phase,
  input  logic [2:0]               sel_kind,
  input  logic [ADDR_W-1:0]        sel_addr,
  input  logic                     sel_word,
  input  logic [DATA_W-1:0]        sel_wdata,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     bhe_n,
  output logic [2:0]               sts,
  output logic                     done,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              k_rd, k_wr, k_rfsh;
  logic              lane_bhe_n;
  logic [DATA_W-1:0] lo_addr;

  logic              d_ale, d_rd_n, d_wr_n, d_den_n, d_bhe_n, d_oe;
  logic [2:0]        d_sts;
  logic [HI_W-1:0]   d_hi;
  logic [DATA_W-1:0] d_ad;

  assign k_rd       = kind_reads(sel_kind);
  assign k_wr       = kind_writes(sel_kind);
  assign k_rfsh     = (sel_kind == CK_REFRESH);
  assign lane_bhe_n = k_rfsh ? 1'b1 : !(sel_word || sel_addr[0]);
  assign lo_addr    = {sel_addr[DATA_W-1:1], sel_addr[0] | k_rfsh};

  always_comb begin
    d_ale   = 1'b0;
    d_rd_n  = 1'b1;
    d_wr_n  = 1'b1;
    d_den_n = 1'b1;
    d_bhe_n = 1'b1;
    d_oe    = 1'b0;
    d_sts   = STS_PASSIVE;
    d_hi    = '0;
    d_ad    = '0;
    case (nxt_phase)
      PH_ADDR: begin
        d_ale   = 1'b1;
        d_sts   = kind_status(sel_kind);
        d_bhe_n = lane_bhe_n;
        d_hi    = sel_addr[ADDR_W-1:DATA_W];
        d_ad    = lo_addr;
        d_oe    = 1'b1;
      end
      PH_STRB, PH_WAIT: begin
        d_bhe_n = lane_bhe_n;
        d_rd_n  = !k_rd;
        d_wr_n  = !k_wr;
        d_den_n = !(k_rd || k_wr);
        if (k_wr) begin
          d_oe = 1'b1;
          d_ad = sel_wdata;
        end
      end
      PH_END: begin
        d_bhe_n = lane_bhe_n;
        d_den_n = !k_wr;
        if (k_wr) begin
          d_oe = 1'b1;
          d_ad = sel_wdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      den_n   <= 1'b1;
      bhe_n   <= 1'b1;
      ad_oe   <= 1'b0;
      sts     <= STS_PASSIVE;
      addr_hi <= '0;
      ad_out  <= '0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      ale     <= d_ale;
      rd_n    <= d_rd_n;
      wr_n    <= d_wr_n;
      den_n   <= d_den_n;
      bhe_n   <= d_bhe_n;
      ad_oe   <= d_oe;
      sts     <= d_sts;
      addr_hi <= d_hi;
      ad_out  <= d_ad;
      done    <= (nxt_phase == PH_END);
      if (phase == PH_WAIT && nxt_phase == PH_END && k_rd)
        rd_data <= ad_in;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (rd_n && wr_n && den_n && bhe_n && !ale && !ad_oe && !done
             && sts == STS_PASSIVE && addr_hi == '0));

  p_sts_passive_r2: assert property (@(posedge clk) disable iff (rst)
    !ale |-> (sts == STS_PASSIVE));

  p_hi_blank_r3: assert property (@(posedge clk) disable iff (rst)
    !ale |-> (addr_hi == '0));

  p_ale_single_r4: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_den_addr_r8: assert property (@(posedge clk) disable iff (rst)
    ale |-> den_n);

  p_rd_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (!den_n && !ad_oe));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_wr_bus_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (ad_oe && !den_n));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_word,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_no_wait,
  output logic                     req_ack,
  input  logic                     ready_in,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     bhe_n,
  output logic [2:0]               sts,
  output logic                     done,
  output logic [DATA_W-1:0]        rd_data
);

  phase_e            phase, nxt_phase;
  logic [2:0]        sel_kind;
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_word;
  logic [DATA_W-1:0] sel_wdata;

  bcc_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_word(req_word), .req_wdata(req_wdata), .req_no_wait(req_no_wait),
    .ready_in(ready_in), .req_ack(req_ack),
    .phase(phase), .nxt_phase(nxt_phase),
    .sel_kind(sel_kind), .sel_addr(sel_addr), .sel_word(sel_word),
    .sel_wdata(sel_wdata)
  );

  bcc_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst),
    .phase(phase), .nxt_phase(nxt_phase),
    .sel_kind(sel_kind), .sel_addr(sel_addr), .sel_word(sel_word),
    .sel_wdata(sel_wdata), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .bhe_n(bhe_n), .sts(sts),
    .done(done), .rd_data(rd_data)
  );

endmodule

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_no_wait = 1'b0;
  logic        req_ack;
  logic        ready_in = 1'b0;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  addr_hi;
  logic        ale, rd_n, wr_n, den_n, bhe_n, done;
  logic [2:0]  sts;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        is_read;
    logic [15:0] data;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
    .req_no_wait(req_no_wait), .req_ack(req_ack), .ready_in(ready_in),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .bhe_n(bhe_n),
    .sts(sts), .done(done), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every done pulse retires one expected item (R9).
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 done with no cycle pending", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_read)
          chk(rd_data == e.data, "R9 read data captured", rd_data, e.data);
      end
    end
  end

  function automatic logic is_rd(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
  endfunction
  function automatic logic is_wr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd6);
  endfunction

  task automatic run_cycle(input logic [2:0] k, input logic [19:0] a,
                           input logic w, input logic [15:0] wd,
                           input logic ign, input int waits,
                           input logic [15:0] rdv);
    logic rk, wk;
    logic [15:0] exp_lo;
    logic exp_bhe;
    int n3;
    exp_t e;
    rk = is_rd(k);
    wk = is_wr(k);
    exp_lo = a[15:0] | {15'd0, (k == 3'd7)};
    exp_bhe = (k == 3'd7) ? 1'b1 : !(w || a[0]);
    n3 = ign ? 1 : waits + 1;
    e.is_read = rk;
    e.data = rdv;
    sb.push_back(e);

    @(negedge clk);
    req_kind = k; req_addr = a; req_word = w; req_wdata = wd;
    req_no_wait = ign; req_valid = 1'b1; ready_in = 1'b0; ad_in = ~rdv;
    #1;
    chk(req_ack == 1'b1, "R12 ack when idle", req_ack, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;

    // first phase
    @(negedge clk);
    chk(ale == 1'b1, "R4 ale in first phase", ale, 1);
    chk(sts == ((k == 3'd7) ? 3'd5 : k), "R2 status code", sts, (k == 3'd7) ? 3'd5 : k);
    chk(addr_hi == a[19:16], "R3 upper address", addr_hi, a[19:16]);
    chk(ad_out == exp_lo && ad_oe, "R3 low address on bus", ad_out, exp_lo);
    chk(bhe_n == exp_bhe && ad_out[0] == exp_lo[0], "R5 lane code", {bhe_n, ad_out[0]}, {exp_bhe, exp_lo[0]});
    chk(den_n && rd_n && wr_n, "R8 no strobe in first phase", {rd_n, wr_n, den_n}, 3'b111);

    // second phase
    @(negedge clk);
    chk(!ale && sts == 3'b111 && addr_hi == 4'd0, "R3 blanked after first phase",
        {ale, sts, addr_hi}, {1'b0, 3'b111, 4'd0});
    chk(rd_n == !rk, "R8 read strobe", rd_n, !rk);
    chk(wr_n == !wk, "R10 write strobe", wr_n, !wk);
    chk(den_n == !(rk || wk), "R11 den only for data", den_n, !(rk || wk));
    if (wk) chk(ad_oe && ad_out == wd, "R10 write data on bus", ad_out, wd);
    else    chk(!ad_oe, "R8 bus released", ad_oe, 0);
    chk(bhe_n == exp_bhe, "R5 bhe held", bhe_n, exp_bhe);

    // third phase and wait clocks
    for (int i = 0; i < n3; i++) begin
      @(negedge clk);
      chk(!done && rd_n == !rk && wr_n == !wk, "R6 still in third phase",
          {done, rd_n, wr_n}, {1'b0, !rk, !wk});
      ready_in = ign ? 1'b0 : (i >= waits);
      ad_in = (i == n3 - 1) ? rdv : ~rdv;
    end

    // fourth phase
    @(negedge clk);
    ad_in = 16'hDEAD;
    ready_in = 1'b0;
    chk(done == 1'b1, ign ? "R7 ready ignored, cycle ends" : "R6 ends after waits", done, 1);
    chk(rd_n && wr_n, "R4 strobes off in fourth phase", {rd_n, wr_n}, 2'b11);
    chk(den_n == !wk, "R10 den through fourth phase", den_n, !wk);
    if (wk) chk(ad_oe && ad_out == wd, "R10 data held in fourth phase", ad_out, wd);
    if (k == 3'd3 || k == 3'd7) chk(!ad_oe, "R11 strobeless bus released", ad_oe, 0);

    // back to idle
    @(negedge clk);
    chk(!done && sts == 3'b111 && !ad_oe && rd_n && wr_n && den_n,
        "R4 idle after cycle", {done, sts, ad_oe}, {1'b0, 3'b111, 1'b0});
    if (rk) chk(rd_data == rdv, "R9 read data held", rd_data, rdv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    #1;
    chk(req_ack == 1'b0, "R1 no ack in reset", req_ack, 0);
    @(negedge clk);
    chk(rd_n && wr_n && den_n && bhe_n && !ale && !ad_oe && !done,
        "R1 strobes idle in reset", {rd_n, wr_n, den_n, bhe_n, ale, ad_oe}, 6'b111100);
    chk(sts == 3'b111 && addr_hi == 4'd0, "R1 passive status in reset", sts, 3'b111);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(sts == 3'b111 && !ale, "R12 no cycle without request", {sts, ale}, 4'b1110);

    run_cycle(3'd5, 20'hA1234, 1'b1, 16'h0000, 1'b0, 0, 16'h5A3C); // memory read word
    run_cycle(3'd6, 20'h30ABC, 1'b1, 16'hBEEF, 1'b0, 2, 16'h0000); // memory write word
    run_cycle(3'd1, 20'h00081, 1'b0, 16'h0000, 1'b1, 0, 16'h00C3); // I/O read odd byte, R7
    run_cycle(3'd2, 20'h00080, 1'b0, 16'h1177, 1'b0, 1, 16'h0000); // I/O write even byte
    run_cycle(3'd4, 20'hFFFF0, 1'b1, 16'h0000, 1'b0, 3, 16'h9012); // fetch, 3 waits
    run_cycle(3'd0, 20'h00000, 1'b0, 16'h0000, 1'b0, 0, 16'h0042); // interrupt acknowledge
    run_cycle(3'd3, 20'h00002, 1'b1, 16'h0000, 1'b0, 1, 16'h0000); // halt, R11
    run_cycle(3'd7, 20'h5ABC4, 1'b1, 16'h0000, 1'b0, 0, 16'h0000); // refresh, R11 R5
    run_cycle(3'd5, 20'h7777B, 1'b0, 16'h0000, 1'b0, 5, 16'hA55A); // odd byte, 5 waits
    run_cycle(3'd6, 20'h12346, 1'b0, 16'h00EE, 1'b1, 0, 16'h0000); // write, ready ignored R7

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R9 every cycle completed", sb.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule